// File: doc/BRIEF.md
# Circular Echo Window with Rotating Filter Store

This block holds the sliding data window and the matching filter columns for a column-at-a-time, one-bit time-domain correlator. Each received echo is a vector of single-bit range samples. It goes into one of a fixed number of column slots. The write position advances cyclically, so the slot that receives a new echo is always the one holding the oldest echo. Stored columns never move sideways. Alignment is kept instead by rotating the much smaller filter store by one column position for every accepted echo. Each data segment therefore always sits beside the filter column whose azimuth lag matches the age of that echo.

After an echo is accepted, the block serves one output column. That column has echo length plus filter length minus one relative range positions. A per-sample step command advances through these positions. Each stored column is held in a ring register whose length equals that number of positions. Every step rotates all rings by one bit. After the last step, every ring is back in its starting layout, ready for the next column. For each column slot the block presents a window of filter-length bits at the current position, together with a per-tap valid mask that marks the zero-padded edges. The correlator downstream combines these windows with the aligned filter bits. An echo that arrives before the current column has finished is dropped and flagged.

Top module: `echo_window_buf`

## Requirements
- R1: After reset, `busy`, `overrun`, `sample_idx`, `wr_col`, `tap_valid`, `data_win` and `filt_win` are all zero. The slot of the newest echo is taken to be P-1.
- R2: An echo accepted while idle is stored in slot `wr_col`. Bit k of `echo_data` is range sample k. `wr_col` then advances by one modulo P (from P-1 to 0), so each new echo replaces the oldest one. `wr_col` does not change while busy.
- R3: On the clock edge that accepts an echo, `busy` becomes 1 and `sample_idx` becomes 0.
- R4: Each `sample_step` while busy advances `sample_idx` by one. The step taken at index L-1, where L = N+Q-1, returns the block to idle with index 0.
- R5: Bits [c*Q+q] of `data_win` equal range sample s-q of the echo in slot c when 0 <= s-q < N, and are 0 otherwise. Here s is `sample_idx`, N the echo length and Q the filter length. `tap_valid[q]` is 1 exactly when the block is busy and that range condition holds.
- R6: Bits [c*Q +: Q] of `filt_win` carry logical filter column (newest - c) mod P, where newest is the slot of the most recently accepted echo. As a result, every accepted echo rotates the filter segments up by one slot.
- R7: A filter write (`filt_wr_en`) with index p stores `filt_wr_data` as logical filter column p. The write is ignored while busy, and also when `echo_valid` is high in the same cycle.
- R8: An echo offered while busy is dropped, leaving the stored data, `wr_col` and the sample position unchanged. `overrun` is 1 in the following cycle only.
- R9: `sample_step` while idle has no effect on `sample_idx`, `busy` or `data_win`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| echo_valid | input | 1 | Offers a new echo this cycle |
| echo_data | input | N | Echo range samples, bit k = sample k |
| sample_step | input | 1 | Advance to the next range position |
| filt_wr_en | input | 1 | Filter column write strobe |
| filt_wr_idx | input | log2(P) | Logical filter column index |
| filt_wr_data | input | Q | Filter column bits |
| busy | output | 1 | An output column is in progress |
| sample_idx | output | log2(L) | Current range position s |
| wr_col | output | log2(P) | Slot that the next echo will fill |
| overrun | output | 1 | One-cycle flag for a dropped echo |
| tap_valid | output | Q | Tap q lies inside the echo |
| data_win | output | P*Q | Data window per slot |
| filt_win | output | P*Q | Aligned filter column per slot |

## Verification
Every result is registered once, so any effect of an input sampled at a rising edge shows up on the ports right after that edge. This covers acceptance, steps, filter writes and the overrun flag. The window and mask outputs then follow combinationally from the new state. The bench changes inputs just after a falling edge and compares all outputs at the next falling edge, exactly one rising edge later. That falling edge is also where the one-cycle overrun pulse is expected, and it must be gone by the edge after.

// File: rtl/ewb_pkg.sv
package ewb_pkg;

    function automatic int wrap_inc(input int v, input int m);
        return (v >= m - 1) ? 0 : v + 1;
    endfunction

    function automatic int wrap_sub(input int a, input int b, input int m);
        return (a >= b) ? a - b : a + m - b;
    endfunction

endpackage

// File: rtl/ewb_sequencer.sv
module ewb_sequencer
    import ewb_pkg::*;
#(
    parameter int NUM_COLS = 8,
    parameter int ECHO_LEN = 32,
    parameter int FILT_LEN = 4,
    localparam int SPAN = ECHO_LEN + FILT_LEN - 1,
    localparam int PW   = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1,
    localparam int SW   = $clog2(SPAN)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                echo_valid,
    input  logic                sample_step,
    input  logic                filt_wr_en,
    input  logic [PW-1:0]       filt_wr_idx,
    output logic                accept,
    output logic                step,
    output logic                filt_we,
    output logic [PW-1:0]       filt_slot,
    output logic [PW-1:0]       wr_col,
    output logic                busy,
    output logic [SW-1:0]       sample_idx,
    output logic                overrun,
    output logic [FILT_LEN-1:0] tap_valid
);

    typedef struct packed {
        logic          busy;
        logic [SW-1:0] sidx;
        logic [PW-1:0] newest;
        logic          overrun;
    } seq_t;

    seq_t st_q, st_d;

    always_comb begin
        st_d      = st_q;
        wr_col    = PW'(wrap_inc(int'(st_q.newest), NUM_COLS));
        accept    = echo_valid && !st_q.busy;
        step      = sample_step && st_q.busy;
        filt_we   = filt_wr_en && !st_q.busy && !echo_valid;
        filt_slot = PW'(wrap_sub(int'(st_q.newest), int'(filt_wr_idx), NUM_COLS));

        st_d.overrun = echo_valid && st_q.busy;
        if (accept) begin
            st_d.busy   = 1'b1;
            st_d.sidx   = '0;
            st_d.newest = wr_col;
        end
        if (step) begin
            if (st_q.sidx == SW'(SPAN - 1)) begin
                st_d.busy = 1'b0;
                st_d.sidx = '0;
            end else begin
                st_d.sidx = st_q.sidx + 1'b1;
            end
        end

        for (int q = 0; q < FILT_LEN; q++) begin
            tap_valid[q] = st_q.busy && (int'(st_q.sidx) >= q)
                           && (int'(st_q.sidx) - q < ECHO_LEN);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.busy    <= 1'b0;
            st_q.sidx    <= '0;
            st_q.newest  <= PW'(NUM_COLS - 1);
            st_q.overrun <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy       = st_q.busy;
    assign sample_idx = st_q.sidx;
    assign overrun    = st_q.overrun;

endmodule

// File: rtl/ewb_ring_bank.sv
module ewb_ring_bank #(
    parameter int NUM_COLS = 8,
    parameter int ECHO_LEN = 32,
    parameter int FILT_LEN = 4,
    localparam int SPAN = ECHO_LEN + FILT_LEN - 1,
    localparam int PW   = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [PW-1:0]                wr_col,
    input  logic [ECHO_LEN-1:0]          wr_echo,
    input  logic                         rot_en,
    output logic [NUM_COLS*FILT_LEN-1:0] data_win
);

    // Position 0 layout: bit i holds sample (-i) modulo SPAN, pads are zero.
    function automatic logic [SPAN-1:0] start_layout(input logic [ECHO_LEN-1:0] e);
        logic [SPAN-1:0] r;
        r    = '0;
        r[0] = e[0];
        for (int i = FILT_LEN; i < SPAN; i++) begin
            r[i] = e[SPAN-i];
        end
        return r;
    endfunction

    for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
        logic [SPAN-1:0] ring_q, ring_d;

        always_comb begin
            ring_d = ring_q;
            if (rot_en) begin
                ring_d = {ring_q[SPAN-2:0], ring_q[SPAN-1]};
            end
            if (wr_en && (wr_col == PW'(c))) begin
                ring_d = start_layout(wr_echo);
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ring_q <= '0;
            end else begin
                ring_q <= ring_d;
            end
        end

        assign data_win[c*FILT_LEN +: FILT_LEN] = ring_q[FILT_LEN-1:0];
    end

endmodule

// File: rtl/ewb_filter_bank.sv
module ewb_filter_bank
    import ewb_pkg::*;
#(
    parameter int NUM_COLS = 8,
    parameter int FILT_LEN = 4,
    localparam int PW = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         rot_en,
    input  logic                         wr_en,
    input  logic [PW-1:0]                wr_slot,
    input  logic [FILT_LEN-1:0]          wr_data,
    output logic [NUM_COLS*FILT_LEN-1:0] filt_win
);

    logic [FILT_LEN-1:0] fb_q [NUM_COLS];
    logic [FILT_LEN-1:0] fb_d [NUM_COLS];

    always_comb begin
        fb_d = fb_q;
        if (rot_en) begin
            for (int c = 0; c < NUM_COLS; c++) begin
                fb_d[c] = fb_q[wrap_sub(c, 1, NUM_COLS)];
            end
        end else if (wr_en) begin
            fb_d[wr_slot] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NUM_COLS; c++) begin
                fb_q[c] <= '0;
            end
        end else begin
            fb_q <= fb_d;
        end
    end

    for (genvar c = 0; c < NUM_COLS; c++) begin : g_out
        assign filt_win[c*FILT_LEN +: FILT_LEN] = fb_q[c];
    end

endmodule

// File: rtl/echo_window_buf.sv
module echo_window_buf #(
    parameter int NUM_COLS = 8,
    parameter int ECHO_LEN = 32,
    parameter int FILT_LEN = 4,
    localparam int SPAN = ECHO_LEN + FILT_LEN - 1,
    localparam int PW   = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1,
    localparam int SW   = $clog2(SPAN)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         echo_valid,
    input  logic [ECHO_LEN-1:0]          echo_data,
    input  logic                         sample_step,
    input  logic                         filt_wr_en,
    input  logic [PW-1:0]                filt_wr_idx,
    input  logic [FILT_LEN-1:0]          filt_wr_data,
    output logic                         busy,
    output logic [SW-1:0]                sample_idx,
    output logic [PW-1:0]                wr_col,
    output logic                         overrun,
    output logic [FILT_LEN-1:0]          tap_valid,
    output logic [NUM_COLS*FILT_LEN-1:0] data_win,
    output logic [NUM_COLS*FILT_LEN-1:0] filt_win
);

    logic          accept;
    logic          step;
    logic          filt_we;
    logic [PW-1:0] filt_slot;

    ewb_sequencer #(
        .NUM_COLS(NUM_COLS), .ECHO_LEN(ECHO_LEN), .FILT_LEN(FILT_LEN)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .echo_valid (echo_valid),
        .sample_step(sample_step),
        .filt_wr_en (filt_wr_en),
        .filt_wr_idx(filt_wr_idx),
        .accept     (accept),
        .step       (step),
        .filt_we    (filt_we),
        .filt_slot  (filt_slot),
        .wr_col     (wr_col),
        .busy       (busy),
        .sample_idx (sample_idx),
        .overrun    (overrun),
        .tap_valid  (tap_valid)
    );

    ewb_ring_bank #(
        .NUM_COLS(NUM_COLS), .ECHO_LEN(ECHO_LEN), .FILT_LEN(FILT_LEN)
    ) u_rings (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (accept),
        .wr_col  (wr_col),
        .wr_echo (echo_data),
        .rot_en  (step),
        .data_win(data_win)
    );

    ewb_filter_bank #(
        .NUM_COLS(NUM_COLS), .FILT_LEN(FILT_LEN)
    ) u_filt (
        .clk     (clk),
        .rst_n   (rst_n),
        .rot_en  (accept),
        .wr_en   (filt_we),
        .wr_slot (filt_slot),
        .wr_data (filt_wr_data),
        .filt_win(filt_win)
    );

endmodule

// File: rtl/ewb_checker.sv
module ewb_checker #(
    parameter int NUM_COLS = 8,
    parameter int ECHO_LEN = 32,
    parameter int FILT_LEN = 4,
    localparam int SPAN = ECHO_LEN + FILT_LEN - 1,
    localparam int PW   = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1,
    localparam int SW   = $clog2(SPAN)
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         echo_valid,
    input logic                         sample_step,
    input logic                         busy,
    input logic [SW-1:0]                sample_idx,
    input logic [PW-1:0]                wr_col,
    input logic                         overrun,
    input logic [FILT_LEN-1:0]          tap_valid,
    input logic [NUM_COLS*FILT_LEN-1:0] data_win
);

    p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (echo_valid && !busy) |=> (busy && sample_idx == '0));

    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (echo_valid && !busy && wr_col == PW'(NUM_COLS - 1)) |=> (wr_col == '0));

    p_hold_col_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(wr_col));

    p_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && sample_step && sample_idx != SW'(SPAN - 1))
        |=> (busy && sample_idx == $past(sample_idx) + 1'b1));

    p_finish_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && sample_step && sample_idx == SW'(SPAN - 1)) |=> (!busy && sample_idx == '0));

    p_idle_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (tap_valid == '0));

    p_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (echo_valid && busy) |=> overrun);

    p_no_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(echo_valid && busy) |=> !overrun);

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !echo_valid) |=> ($stable(data_win) && !busy && sample_idx == '0));

endmodule

bind echo_window_buf ewb_checker #(
    .NUM_COLS(NUM_COLS), .ECHO_LEN(ECHO_LEN), .FILT_LEN(FILT_LEN)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .echo_valid (echo_valid),
    .sample_step(sample_step),
    .busy       (busy),
    .sample_idx (sample_idx),
    .wr_col     (wr_col),
    .overrun    (overrun),
    .tap_valid  (tap_valid),
    .data_win   (data_win)
);

// File: tb/echo_window_buf_test.sv
module echo_window_buf_test;

    localparam int P  = 8;
    localparam int N  = 32;
    localparam int Q  = 4;
    localparam int L  = N + Q - 1;
    localparam int PW = 3;
    localparam int SW = 6;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           echo_valid = 1'b0;
    logic [N-1:0]   echo_data = '0;
    logic           sample_step = 1'b0;
    logic           filt_wr_en = 1'b0;
    logic [PW-1:0]  filt_wr_idx = '0;
    logic [Q-1:0]   filt_wr_data = '0;
    logic           busy;
    logic [SW-1:0]  sample_idx;
    logic [PW-1:0]  wr_col;
    logic           overrun;
    logic [Q-1:0]   tap_valid;
    logic [P*Q-1:0] data_win;
    logic [P*Q-1:0] filt_win;

    always #4 clk = ~clk;

    echo_window_buf #(.NUM_COLS(P), .ECHO_LEN(N), .FILT_LEN(Q)) uut (
        .clk(clk), .rst_n(rst_n), .echo_valid(echo_valid), .echo_data(echo_data),
        .sample_step(sample_step), .filt_wr_en(filt_wr_en), .filt_wr_idx(filt_wr_idx),
        .filt_wr_data(filt_wr_data), .busy(busy), .sample_idx(sample_idx),
        .wr_col(wr_col), .overrun(overrun), .tap_valid(tap_valid),
        .data_win(data_win), .filt_win(filt_win)
    );

    int n_checks = 0;
    int n_fail   = 0;

    // Reference state, kept from the requirements alone.
    logic [N-1:0] mv [P];
    logic [Q-1:0] mh [P];
    int  mnew  = P - 1;
    int  ms    = 0;
    bit  mbusy = 1'b0;
    bit  mover = 1'b0;

    task automatic chk(input string tag, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        logic [P*Q-1:0] ed;
        logic [P*Q-1:0] ef;
        logic [Q-1:0]   et;
        ed = '0; ef = '0; et = '0;
        for (int c = 0; c < P; c++) begin
            for (int q = 0; q < Q; q++) begin
                if (ms - q >= 0 && ms - q < N) ed[c*Q+q] = mv[c][ms-q];
            end
            ef[c*Q +: Q] = mh[(mnew - c + P) % P];
        end
        for (int q = 0; q < Q; q++) et[q] = mbusy && (ms - q >= 0) && (ms - q < N);
        chk(tag, "busy",       256'(busy),       256'(mbusy));
        chk(tag, "sample_idx", 256'(sample_idx), 256'(ms));
        chk(tag, "wr_col",     256'(wr_col),     256'((mnew + 1) % P));
        chk(tag, "overrun",    256'(overrun),    256'(mover));
        chk(tag, "tap_valid",  256'(tap_valid),  256'(et));
        chk(tag, "data_win",   256'(data_win),   256'(ed));
        chk(tag, "filt_win",   256'(filt_win),   256'(ef));
    endtask

    // One clock: inputs applied after a falling edge, checked at the next one.
    task automatic drive(input string tag, input bit ev, input logic [N-1:0] ed,
                         input bit st, input bit fw, input int fi, input logic [Q-1:0] fd);
        bit acc, stp, fwe;
        echo_valid = ev; echo_data = ed; sample_step = st;
        filt_wr_en = fw; filt_wr_idx = PW'(fi); filt_wr_data = fd;
        acc = ev && !mbusy;
        stp = st && mbusy;
        fwe = fw && !mbusy && !ev;
        mover = ev && mbusy;
        if (fwe) mh[fi] = fd;
        if (stp) begin
            if (ms == L - 1) begin mbusy = 1'b0; ms = 0; end
            else ms++;
        end
        if (acc) begin
            mnew = (mnew + 1) % P;
            mv[mnew] = ed;
            mbusy = 1'b1;
            ms = 0;
        end
        @(negedge clk);
        echo_valid = 1'b0; sample_step = 1'b0; filt_wr_en = 1'b0;
        check_all(tag);
    endtask

    function automatic logic [N-1:0] pat(input int k);
        return N'(32'hA5C3_1E77 ^ (32'(k) * 32'h9E37_79B9));
    endfunction

    task automatic run_column(input string tag);
        for (int i = 0; i < L; i++) drive(tag, 0, '0, 1, 0, 0, '0);
    endtask

    task automatic sc_reset();
        check_all("R1");
    endtask

    task automatic sc_filter_load();
        for (int p = 0; p < P; p++) drive("R7_R6", 0, '0, 0, 1, p, Q'(p * 5 + 3));
    endtask

    task automatic sc_first_column();
        drive("R2_R3", 1, pat(1), 0, 0, 0, '0);
        run_column("R4_R5");
    endtask

    task automatic sc_overrun();
        drive("R3", 1, pat(2), 0, 0, 0, '0);
        drive("R4", 0, '0, 1, 0, 0, '0);
        drive("R8", 1, pat(99), 0, 0, 0, '0);
        drive("R8_pulse", 0, '0, 1, 0, 0, '0);
        drive("R8_step", 1, pat(98), 1, 0, 0, '0);
        for (int i = 0; i < L - 2; i++) drive("R4_R8", 0, '0, 1, 0, 0, '0);
    endtask

    task automatic sc_idle_step();
        drive("R9", 0, '0, 1, 0, 0, '0);
        drive("R9", 0, '0, 1, 0, 0, '0);
    endtask

    task automatic sc_filter_blocked();
        drive("R7_echo_wins", 1, pat(3), 0, 1, 2, 4'hF);
        drive("R7_busy", 0, '0, 1, 1, 1, 4'h0);
        drive("R7_busy", 0, '0, 0, 1, 5, 4'h9);
        for (int i = 0; i < L - 1; i++) drive("R4", 0, '0, 1, 0, 0, '0);
        drive("R7_idle", 0, '0, 0, 1, 6, 4'hC);
    endtask

    task automatic sc_wrap();
        for (int k = 0; k < P + 2; k++) begin
            drive("R2_R6", 1, pat(10 + k), 0, 0, 0, '0);
            run_column("R5");
        end
    endtask

    initial begin
        for (int c = 0; c < P; c++) begin mv[c] = '0; mh[c] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        sc_reset();
        sc_filter_load();
        sc_first_column();
        sc_overrun();
        sc_idle_step();
        sc_filter_blocked();
        sc_wrap();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule